// File: doc/BRIEF.md
# System Bus DMA Master Sequencer

This block sequences the host-facing bus of a network coprocessor. It serves slave register accesses from the host (DIO) while the host's active-low chip select is low. It also runs bus-master DMA transfers of a programmed number of words. For each DMA word it wins the system bus, pulses an address-latch strobe and runs one data phase. It drives the external data-buffer enable and the data-direction line. It also drives a shared control pin that serves either host style: byte-high-enable, or read/not-write.

A transfer is requested with a one-cycle request pulse carrying a start address, a word count and a direction. The sequencer states are IDLE, HOLD, ARBITRATE, ADDRESS, DATA, RELEASE and DONE. The transitions are:
- IDLE → ARBITRATE on an accepted request when chip select is high.
- IDLE → HOLD on an accepted request when chip select is low.
- HOLD → ARBITRATE once chip select rises.
- ARBITRATE → ADDRESS when the synchronized bus-free line and grant are both high.
- ADDRESS → DATA always.
- DATA → DONE on the last word.
- DATA → RELEASE when a synchronized release request is pending and words remain.
- DATA → ADDRESS otherwise.
- RELEASE → ARBITRATE always.
- DONE → IDLE always.

The bus-free and release inputs pass through two-flop synchronizers before use.

Top module: `sbus_dma_seq`

## Requirements
- R1: After reset `ale_o`, `own_o`, `done_o` and `ctl_oe_o` are 0, while `dben_n_o` and `ddir_o` are 1.
- R2: The bus is taken (`own_o` rises) only from ARBITRATE. It requires `busy_n_i` high (bus free) after two-flop synchronization and `grant_i` high. While either is low, no address strobe appears.
- R3: Each DMA word gives exactly one one-cycle `ale_o` pulse. During that pulse, `addr_o` shows the word address. The first address is the requested start address, and each later one adds `WORD_BYTES`.
- R4: `dben_n_o` is 0 during DMA address and data phases, and during a DIO access. A DIO access means `cs_n_i` is 0 while the sequencer is in IDLE or HOLD. Otherwise `dben_n_o` is 1.
- R5: `ddir_o` is 0 for DIO writes (`dio_wr_i`=1) and for DMA reads (`xfer_wr_i`=0). It is 1 for DIO reads and DMA writes, and 1 when neither DIO nor DMA is active.
- R6: `ctl_oe_o` is 1 only while the bus is owned. `ctl_o` is then 0 in byte-enable style (`style_rnw_i`=0). In read/not-write style (`style_rnw_i`=1), `ctl_o` is 1 for a DMA read and 0 for a DMA write.
- R7: If the synchronized release request (`rel_n_i` low) is seen in a data phase with words left, the bus is dropped for one RELEASE cycle. The sequencer then rearbitrates and continues at the next address.
- R8: A release request while no DMA is in progress has no effect. A later transfer runs with a single bus tenure.
- R9: A request accepted during a DIO access waits in HOLD, with no strobe, until `cs_n_i` rises. The DIO access is still served meanwhile.
- R10: `done_o` pulses for one cycle after the last data phase, even if release is pending. At that point no further words are owed.
- R11: A request with zero length, or one arriving while a transfer is in progress, is ignored.
- R12: A transfer of N words produces exactly N address strobes, counted by a word counter that never steps below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock |
| rst_n | input | 1 | Active-low reset |
| busy_n_i | input | 1 | Bus state sample, high = bus free (asynchronous) |
| rel_n_i | input | 1 | Release request from higher-priority master, active low (asynchronous) |
| cs_n_i | input | 1 | Host chip select for DIO, active low |
| dio_wr_i | input | 1 | DIO direction, 1 = host writes into the device |
| grant_i | input | 1 | Bus grant condition |
| style_rnw_i | input | 1 | Host style, 0 = byte-high-enable, 1 = read/not-write |
| xfer_req_i | input | 1 | One-cycle DMA request |
| xfer_addr_i | input | ADDR_W | DMA start address |
| xfer_len_i | input | CNT_W | DMA word count |
| xfer_wr_i | input | 1 | DMA direction, 1 = write (data out of device) |
| addr_o | output | ADDR_W | Current DMA word address |
| ale_o | output | 1 | Address-latch strobe |
| dben_n_o | output | 1 | Data-buffer enable, active low |
| ddir_o | output | 1 | Data direction, 1 = out of device |
| ctl_o | output | 1 | Shared control pin value |
| ctl_oe_o | output | 1 | Shared control pin drive enable |
| own_o | output | 1 | Bus mastership held |
| done_o | output | 1 | Transfer complete pulse |

## Verification
The hardest case is a release request landing in the middle of a transfer. It must break the transfer into separate bus tenures without losing or repeating a word. It must also not delay completion on the final word. The stimulus holds the release line low well ahead of a request, so the synchronizer has settled by the first data phase. The bench then counts the falling edges of bus ownership against the number of strobes and their addresses. A request arriving during a DIO access is produced by holding chip select low across the request pulse.

// File: rtl/sbus_seq_pkg.sv
package sbus_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_ARB,
        ST_ADDR,
        ST_DATA,
        ST_REL,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/sbus_sync2.sv
module sbus_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dma_word_ctr.sv
module dma_word_ctr #(
    parameter int ADDR_W     = 24,
    parameter int CNT_W      = 16,
    parameter int WORD_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [CNT_W-1:0]  ld_len,
    input  logic              ld_wr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last,
    output logic              wr
);
    localparam logic [ADDR_W-1:0] ADDR_INC = ADDR_W'(WORD_BYTES);
    localparam logic [CNT_W-1:0]  ONE      = CNT_W'(1);

    logic [CNT_W-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
            left <= '0;
            wr   <= 1'b0;
        end else if (load) begin
            addr <= ld_addr;
            left <= ld_len;
            wr   <= ld_wr;
        end else if (step) begin
            addr <= addr + ADDR_INC;
            left <= left - ONE;
        end
    end

    assign last = (left == ONE);

    // R12
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (left != '0));
endmodule

// File: rtl/sbus_seq_fsm.sv
module sbus_seq_fsm
    import sbus_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_ok,
    input  logic cs_n_i,
    input  logic bus_free,
    input  logic grant_i,
    input  logic rel_n_s,
    input  logic last,
    output logic load,
    output logic step,
    output logic own,
    output logic ale,
    output logic done,
    output logic dio_win
);
    seq_state_e st, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt  = st;
        load = 1'b0;
        step = 1'b0;
        unique case (st)
            ST_IDLE: if (req_ok) begin
                load = 1'b1;
                nxt  = cs_n_i ? ST_ARB : ST_HOLD;
            end
            ST_HOLD: if (cs_n_i) nxt = ST_ARB;
            ST_ARB:  if (bus_free && grant_i) nxt = ST_ADDR;
            ST_ADDR: nxt = ST_DATA;
            ST_DATA: begin
                step = 1'b1;
                if (last)          nxt = ST_DONE;
                else if (!rel_n_s) nxt = ST_REL;
                else               nxt = ST_ADDR;
            end
            ST_REL:  nxt = ST_ARB;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        own     = (st == ST_ADDR) || (st == ST_DATA);
        ale     = (st == ST_ADDR);
        done    = (st == ST_DONE);
        dio_win = (st == ST_IDLE) || (st == ST_HOLD);
    end

    // R2
    arb_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR && $past(st) == ST_ARB) |-> $past(bus_free && grant_i));
    // R7
    rel_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_REL) |-> ($past(st) == ST_DATA && !$past(rel_n_s)));
endmodule

// File: rtl/sbus_dma_seq.sv
module sbus_dma_seq #(
    parameter int ADDR_W     = 24,
    parameter int CNT_W      = 16,
    parameter int WORD_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_n_i,
    input  logic              rel_n_i,
    input  logic              cs_n_i,
    input  logic              dio_wr_i,
    input  logic              grant_i,
    input  logic              style_rnw_i,
    input  logic              xfer_req_i,
    input  logic [ADDR_W-1:0] xfer_addr_i,
    input  logic [CNT_W-1:0]  xfer_len_i,
    input  logic              xfer_wr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              ale_o,
    output logic              dben_n_o,
    output logic              ddir_o,
    output logic              ctl_o,
    output logic              ctl_oe_o,
    output logic              own_o,
    output logic              done_o
);
    logic bus_free, rel_n_s;
    logic load, step, last, wr, dio_win, dio_act, req_ok;

    sbus_sync2 #(.RST_VAL(1'b0)) u_busy_sync (
        .clk(clk), .rst_n(rst_n), .d(busy_n_i), .q(bus_free));

    sbus_sync2 #(.RST_VAL(1'b1)) u_rel_sync (
        .clk(clk), .rst_n(rst_n), .d(rel_n_i), .q(rel_n_s));

    assign req_ok = xfer_req_i && (xfer_len_i != '0);

    sbus_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_ok(req_ok), .cs_n_i(cs_n_i),
        .bus_free(bus_free), .grant_i(grant_i), .rel_n_s(rel_n_s),
        .last(last), .load(load), .step(step), .own(own_o),
        .ale(ale_o), .done(done_o), .dio_win(dio_win));

    dma_word_ctr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(load), .ld_addr(xfer_addr_i),
        .ld_len(xfer_len_i), .ld_wr(xfer_wr_i), .step(step),
        .addr(addr_o), .last(last), .wr(wr));

    always_comb begin
        dio_act  = dio_win && !cs_n_i;
        dben_n_o = !(own_o || dio_act);
        if (own_o)        ddir_o = wr;
        else if (dio_act) ddir_o = !dio_wr_i;
        else              ddir_o = 1'b1;
        ctl_oe_o = own_o;
        ctl_o    = style_rnw_i ? !wr : 1'b0;
    end

    // R3
    ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> !ale_o);
    // R4
    ale_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> !dben_n_o);
    // R5
    dir_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dben_n_o |-> ddir_o);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: tb/test_sbus_dma_seq.sv
module test_sbus_dma_seq;
    localparam int AW = 24;
    localparam int CW = 16;
    localparam int WB = 2;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          dir;
        logic          ctl;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic busy_n = 1'b1, rel_n = 1'b1, cs_n = 1'b1, dio_wr = 1'b0;
    logic grant = 1'b1, style = 1'b0, req = 1'b0, xwr = 1'b0;
    logic [AW-1:0] xaddr = '0;
    logic [CW-1:0] xlen = '0;
    logic [AW-1:0] addr;
    logic ale, dben_n, ddir, ctl, ctl_oe, own, done;

    int checks = 0, fails = 0;
    int ale_cnt = 0, done_cnt = 0, own_falls = 0;
    logic own_q = 1'b0;
    exp_t sb[$];

    always #10 clk = ~clk;

    sbus_dma_seq #(.ADDR_W(AW), .CNT_W(CW), .WORD_BYTES(WB)) i_sbus_dma_seq (
        .clk(clk), .rst_n(rst_n), .busy_n_i(busy_n), .rel_n_i(rel_n),
        .cs_n_i(cs_n), .dio_wr_i(dio_wr), .grant_i(grant),
        .style_rnw_i(style), .xfer_req_i(req), .xfer_addr_i(xaddr),
        .xfer_len_i(xlen), .xfer_wr_i(xwr), .addr_o(addr), .ale_o(ale),
        .dben_n_o(dben_n), .ddir_o(ddir), .ctl_o(ctl), .ctl_oe_o(ctl_oe),
        .own_o(own), .done_o(done));

    task automatic chk(input logic ok, input string req_tag,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // monitor: pops expected words at each strobe
    always @(negedge clk) begin
        if (rst_n) begin
            if (own_q && !own) own_falls++;
            own_q <= own;
            if (ale) begin
                ale_cnt++;
                if (sb.size() == 0) begin
                    chk(1'b0, "R11 unexpected strobe", addr, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(addr == e.addr, "R3 addr", addr, e.addr);
                    chk(dben_n == 1'b0, "R4 dben in dma", dben_n, 0);
                    chk(ddir == e.dir, "R5 dma dir", ddir, e.dir);
                    chk(ctl_oe == 1'b1 && ctl == e.ctl, "R6 ctl pin",
                        {ctl_oe, ctl}, {1'b1, e.ctl});
                end
            end
            if (done) begin
                done_cnt++;
                chk(sb.size() == 0, "R10 R12 words owed at done", sb.size(), 0);
            end
        end
    end

    task automatic start_dma(input logic [AW-1:0] a, input int n, input logic w);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.addr = a + AW'(i * WB);
            e.dir  = w;
            e.ctl  = style ? !w : 1'b0;
            sb.push_back(e);
        end
        @(negedge clk);
        xaddr = a; xlen = CW'(n); xwr = w; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int d0;
        d0 = done_cnt;
        for (int i = 0; i < 400; i++) begin
            if (done_cnt != d0) break;
            @(negedge clk);
        end
        chk(done_cnt == d0 + 1, tag, done_cnt - d0, 1);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int a0, f0, d0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk({ale, own, done, ctl_oe} == 4'b0, "R1 strobes", {ale, own, done, ctl_oe}, 0);
        chk(dben_n && ddir, "R1 buffer/dir idle", {dben_n, ddir}, 2'b11);
        repeat (4) @(negedge clk);

        // DMA read, byte style
        f0 = own_falls;
        start_dma(24'h000100, 3, 1'b0);
        wait_done("R10 done read");
        chk(own_falls == f0 + 1, "R7 single tenure", own_falls - f0, 1);

        // DMA write, read/not-write style
        style = 1'b1;
        start_dma(24'hFFFFFC, 4, 1'b1);
        wait_done("R10 done write");
        start_dma(24'h000200, 2, 1'b0);
        wait_done("R6 rnw read");
        style = 1'b0;

        // R2 bus busy
        busy_n = 1'b0;
        repeat (4) @(negedge clk);
        a0 = ale_cnt;
        start_dma(24'h000300, 2, 1'b0);
        repeat (20) @(negedge clk);
        chk(ale_cnt == a0 && !own, "R2 busy blocks", ale_cnt - a0, 0);
        busy_n = 1'b1;
        wait_done("R2 after busy");

        // R2 no grant
        grant = 1'b0;
        a0 = ale_cnt;
        start_dma(24'h000400, 1, 1'b1);
        repeat (20) @(negedge clk);
        chk(ale_cnt == a0 && !own, "R2 grant blocks", ale_cnt - a0, 0);
        grant = 1'b1;
        wait_done("R2 after grant");

        // R7 release held: each word its own tenure, R10 done still given
        rel_n = 1'b0;
        repeat (4) @(negedge clk);
        f0 = own_falls; a0 = ale_cnt;
        start_dma(24'h000500, 3, 1'b0);
        wait_done("R10 done under release");
        chk(own_falls == f0 + 3, "R7 rearbitrations", own_falls - f0, 3);
        chk(ale_cnt == a0 + 3, "R12 strobe count", ale_cnt - a0, 3);

        // R8 release while idle: no effect
        repeat (4) @(negedge clk);
        chk(!own && dben_n && ddir && !ale, "R8 idle outputs", {own, dben_n, ddir, ale}, 4'b0110);
        rel_n = 1'b1;
        repeat (4) @(negedge clk);
        f0 = own_falls;
        start_dma(24'h000600, 2, 1'b1);
        wait_done("R8 done");
        chk(own_falls == f0 + 1, "R8 single tenure", own_falls - f0, 1);

        // DIO read and write
        cs_n = 1'b0; dio_wr = 1'b0;
        @(negedge clk);
        chk(!dben_n && ddir, "R4 R5 dio read", {dben_n, ddir}, 2'b01);
        dio_wr = 1'b1;
        @(negedge clk);
        chk(!dben_n && !ddir, "R4 R5 dio write", {dben_n, ddir}, 2'b00);

        // R9 request during DIO waits
        a0 = ale_cnt;
        start_dma(24'h000700, 2, 1'b0);
        repeat (10) @(negedge clk);
        chk(ale_cnt == a0, "R9 held during dio", ale_cnt - a0, 0);
        chk(!dben_n && !ddir, "R9 dio served in hold", {dben_n, ddir}, 2'b00);
        cs_n = 1'b1;
        @(negedge clk);
        chk(dben_n && ddir, "R4 dio ended", {dben_n, ddir}, 2'b11);
        wait_done("R9 runs after dio");

        // R11 zero length
        a0 = ale_cnt; d0 = done_cnt;
        @(negedge clk);
        xlen = '0; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        repeat (10) @(negedge clk);
        chk(ale_cnt == a0 && done_cnt == d0, "R11 zero length", ale_cnt - a0, 0);

        // R11 request during transfer ignored
        a0 = ale_cnt;
        start_dma(24'h000800, 4, 1'b1);
        repeat (3) @(negedge clk);
        xaddr = 24'h009000; xlen = CW'(5); req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        wait_done("R11 first completes");
        repeat (20) @(negedge clk);
        chk(ale_cnt == a0 + 4, "R11 mid-transfer request", ale_cnt - a0, 4);

        summary();
    end
endmodule